// File: doc/BRIEF.md
# Section Address Translation Unit

This block maps 32-bit virtual addresses onto physical addresses in 1 MB granules. Each granule is described by one 32-bit descriptor word in a table of 4096 words held in memory. The top twelve bits of a virtual address select that table word. The word supplies the twelve upper physical bits, a four-bit protection group number, two access-rights bits and the cacheable and bufferable attributes. The low twenty address bits pass through untouched.

Descriptor reads go out on a physical read port without any translation. A 32-bit group control word gives each of the sixteen protection groups one of four modes: blocked, checked, unchecked, or reserved. A four-entry fully associative cache keeps recently used descriptors, so a repeated access to the same granule needs no table read.

The controller has two states:

- IDLE accepts requests.
  - A disabled unit or a cache hit stays in IDLE (IDLE to IDLE) and answers on the next cycle.
  - A cache miss moves to WALK (IDLE to WALK).
- WALK holds the descriptor read.
  - It stays in WALK (WALK to WALK) until memory answers.
  - It then returns to IDLE (WALK to IDLE), registering the response and filling the cache.

Software configures the unit through a small write port with four addresses:

| cfg_addr | Function |
|---|---|
| 0 | table base |
| 1 | group control word |
| 2 | enable (bit 0) |
| 3 | invalidate every cached descriptor (any write) |

Top module: `sx_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_rd_valid are 0, translation is off and the descriptor cache holds no entries.
- R2: While translation is off, an accepted request is answered in the cycle after acceptance, with rsp_paddr equal to the virtual address, rsp_cacheable = rsp_bufferable = 0 and no fault, and no descriptor read is issued.
- R3: On a cache miss, the descriptor read address is the table base OR (virtual bits 31:20 shifted left by 2). Bits 13:0 written to the base register are ignored and read as zero.
- R4: A descriptor is a valid section only when its bits 1:0 are 2'b10 and its bit 18 is 0. Any other word gives fault kind 2'b01 (translation).
- R5: A permitted access returns rsp_paddr = {descriptor[31:20], virtual[19:0]}, rsp_cacheable = descriptor[3] and rsp_bufferable = descriptor[2].
- R6: Descriptor bits 8:5 pick group n, whose mode is bits 2n+1:2n of the group control word. Mode 2'b00 (blocked) and mode 2'b10 (reserved) give fault kind 2'b10 (domain).
- R7: Mode 2'b11 (unchecked) never gives a rights fault, whatever the access-rights bits say.
- R8: Under mode 2'b01 (checked), the access-rights bits are descriptor[11:10]. Value 2'b00 faults every access; 2'b10 faults writes and allows reads; 2'b01 and 2'b11 allow all accesses. A rights fault has kind 2'b11.
- R9: A faulting response has rsp_fault = 1, the kind on rsp_fault_kind and the virtual address on rsp_fault_addr, with rsp_paddr, rsp_cacheable and rsp_bufferable all 0. A clean response has kind 2'b00 and rsp_fault_addr 0.
- R10: A cache hit is answered in the cycle after acceptance without a descriptor read. It is judged against the group control word current at that time, so a mode change takes effect without invalidation.
- R11: The cache holds 4 entries tagged by virtual bits 31:20. Valid sections are filled into slots in rotating order starting at slot 0, so the fifth distinct granule displaces the first.
- R12: A write to cfg_addr 3 clears every cache entry and returns the fill order to slot 0. Until then, a changed table word is not seen for a granule that is already cached.
- R13: During a descriptor read, mem_rd_valid and mem_rd_addr stay steady and req_ready stays 0 until mem_rd_resp. The response is registered on the edge where mem_rd_resp is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | translation request present |
| req_ready | output | 1 | request can be taken (IDLE) |
| req_vaddr | input | 32 | virtual address |
| req_write | input | 1 | 1 for a write access |
| mem_rd_valid | output | 1 | descriptor read pending |
| mem_rd_addr | output | 32 | physical address of the descriptor |
| mem_rd_resp | input | 1 | read data returned this cycle |
| mem_rd_data | input | 32 | descriptor word |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | 2 | 0 base, 1 group control, 2 enable, 3 invalidate-all |
| cfg_wdata | input | 32 | configuration write data |
| rsp_valid | output | 1 | one-cycle response strobe |
| rsp_paddr | output | 32 | physical address |
| rsp_cacheable | output | 1 | region may be cached |
| rsp_bufferable | output | 1 | writes may be buffered |
| rsp_fault | output | 1 | access refused |
| rsp_fault_kind | output | 2 | 0 none, 1 translation, 2 domain, 3 rights |
| rsp_fault_addr | output | 32 | virtual address of a refused access |

## Verification
Some rules are checked by assertions on every cycle:
- the descriptor-read handshake holds steady and keeps req_ready low;
- a refused access never carries a physical address or attributes;
- clean responses keep the low twenty address bits;
- faults report the accepted virtual address;
- a response never appears without a preceding acceptance or read return.

Other behaviours only the directed scenarios can show:
- the mapping of descriptor fields to address, attributes and fault kind;
- the decoding of group modes and rights;
- hit versus miss timing;
- stale hits before invalidation;
- the rotating replacement order.

// File: rtl/sx_pkg.sv
package sx_pkg;
    localparam int ADDR_W  = 32;
    localparam int TAG_W   = 12;
    localparam int OFF_W   = ADDR_W - TAG_W;
    localparam int ALIGN_W = 14;

    typedef enum logic [1:0] {
        FK_NONE   = 2'b00,
        FK_XLATE  = 2'b01,
        FK_DOMAIN = 2'b10,
        FK_PERM   = 2'b11
    } fault_kind_t;

    typedef struct packed {
        logic [ADDR_W-1:0] paddr;
        logic              cach;
        logic              buff;
        logic              fault;
        fault_kind_t       kind;
    } xl_res_t;

    function automatic logic sx_is_section(input logic [31:0] d);
        return (d[1:0] == 2'b10) && !d[18];
    endfunction

    // Judge one access against a descriptor and the group control word.
    function automatic xl_res_t sx_judge(input logic [31:0] d,
                                         input logic [31:0] va,
                                         input logic        wr,
                                         input logic [31:0] grp);
        xl_res_t    r;
        logic [1:0] mode;
        logic [1:0] ap;
        r    = '0;
        mode = grp[{d[8:5], 1'b0} +: 2];
        ap   = d[11:10];
        if (!sx_is_section(d))
            r.kind = FK_XLATE;
        else if (mode == 2'b00 || mode == 2'b10)
            r.kind = FK_DOMAIN;
        else if (mode == 2'b01 && (ap == 2'b00 || (ap == 2'b10 && wr)))
            r.kind = FK_PERM;
        else begin
            r.kind  = FK_NONE;
            r.paddr = {d[31:OFF_W], va[OFF_W-1:0]};
            r.cach  = d[3];
            r.buff  = d[2];
        end
        r.fault = (r.kind != FK_NONE);
        return r;
    endfunction
endpackage

// File: rtl/sx_regs.sv
module sx_regs
    import sx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [31:0]       grp_ctl,
    output logic              xl_en,
    output logic              flush
);
    assign flush = cfg_we && (cfg_addr == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_base <= '0;
            grp_ctl  <= '0;
            xl_en    <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                2'd0:    tbl_base <= {cfg_wdata[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                2'd1:    grp_ctl  <= cfg_wdata;
                2'd2:    xl_en    <= cfg_wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sx_tlb.sv
module sx_tlb
    import sx_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [31:0]      fill_desc,
    input  logic             flush,
    output logic             hit,
    output logic [31:0]      hit_desc
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld;
    logic [TAG_W-1:0] tag  [N];
    logic [31:0]      desc [N];
    logic [N-1:0]     match;
    logic [PW-1:0]    ptr;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == lk_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_desc = '0;
        for (int i = 0; i < N; i++)
            if (match[i]) hit_desc = hit_desc | desc[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
            for (int i = 0; i < N; i++) begin
                tag[i]  <= '0;
                desc[i] <= '0;
            end
        end else if (flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (fill_en) begin
            vld[ptr]  <= 1'b1;
            tag[ptr]  <= fill_tag;
            desc[ptr] <= fill_desc;
            ptr       <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/sx_walk.sv
module sx_walk
    import sx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    output logic              req_ready,
    input  logic              xl_en,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [31:0]       grp_ctl,
    input  logic              flush,
    input  logic              hit,
    input  logic [31:0]       hit_desc,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_resp,
    input  logic [31:0]       mem_rd_data,
    output logic              fill_en,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              rsp_valid,
    output xl_res_t           rsp_q,
    output logic [ADDR_W-1:0] rsp_fault_addr
);
    typedef enum logic {S_IDLE, S_WALK} st_t;

    st_t               st, st_nxt;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              rsp_load;
    xl_res_t           rsp_d;
    logic [ADDR_W-1:0] cur_va;

    assign mem_rd_addr = tbl_base | (ADDR_W'(va_q[ADDR_W-1:OFF_W]) << 2);
    assign fill_tag    = va_q[ADDR_W-1:OFF_W];
    assign cur_va      = (st == S_IDLE) ? req_vaddr : va_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    // Next state and outputs
    always_comb begin
        st_nxt       = st;
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        fill_en      = 1'b0;
        rsp_load     = 1'b0;
        rsp_d        = '0;
        unique case (st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (!xl_en) begin
                        rsp_load    = 1'b1;
                        rsp_d.paddr = req_vaddr;
                    end else if (hit) begin
                        rsp_load = 1'b1;
                        rsp_d    = sx_judge(hit_desc, req_vaddr, req_write, grp_ctl);
                    end else begin
                        st_nxt = S_WALK;
                    end
                end
            end
            S_WALK: begin
                mem_rd_valid = 1'b1;
                if (mem_rd_resp) begin
                    rsp_load = 1'b1;
                    rsp_d    = sx_judge(mem_rd_data, va_q, wr_q, grp_ctl);
                    fill_en  = sx_is_section(mem_rd_data) && !flush;
                    st_nxt   = S_IDLE;
                end
            end
        endcase
    end

    // Request capture and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q           <= '0;
            wr_q           <= 1'b0;
            rsp_valid      <= 1'b0;
            rsp_q          <= '0;
            rsp_fault_addr <= '0;
        end else begin
            if (req_ready && req_valid) begin
                va_q <= req_vaddr;
                wr_q <= req_write;
            end
            rsp_valid <= rsp_load;
            if (rsp_load) begin
                rsp_q          <= rsp_d;
                rsp_fault_addr <= rsp_d.fault ? cur_va : '0;
            end
        end
    end
endmodule

// File: rtl/sx_unit.sv
module sx_unit
    import sx_pkg::*;
#(
    parameter int TLB_N = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_resp,
    input  logic [31:0] mem_rd_data,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_cacheable,
    output logic        rsp_bufferable,
    output logic        rsp_fault,
    output logic [1:0]  rsp_fault_kind,
    output logic [31:0] rsp_fault_addr
);
    logic [ADDR_W-1:0] tbl_base;
    logic [31:0]       grp_ctl;
    logic              xl_en;
    logic              flush;
    logic              hit;
    logic [31:0]       hit_desc;
    logic              fill_en;
    logic [TAG_W-1:0]  fill_tag;
    xl_res_t           rsp_q;

    sx_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .tbl_base (tbl_base),
        .grp_ctl  (grp_ctl),
        .xl_en    (xl_en),
        .flush    (flush)
    );

    sx_tlb #(.N(TLB_N)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (req_vaddr[ADDR_W-1:OFF_W]),
        .fill_en  (fill_en),
        .fill_tag (fill_tag),
        .fill_desc(mem_rd_data),
        .flush    (flush),
        .hit      (hit),
        .hit_desc (hit_desc)
    );

    sx_walk u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_ready     (req_ready),
        .xl_en         (xl_en),
        .tbl_base      (tbl_base),
        .grp_ctl       (grp_ctl),
        .flush         (flush),
        .hit           (hit),
        .hit_desc      (hit_desc),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_resp   (mem_rd_resp),
        .mem_rd_data   (mem_rd_data),
        .fill_en       (fill_en),
        .fill_tag      (fill_tag),
        .rsp_valid     (rsp_valid),
        .rsp_q         (rsp_q),
        .rsp_fault_addr(rsp_fault_addr)
    );

    assign rsp_paddr      = rsp_q.paddr;
    assign rsp_cacheable  = rsp_q.cach;
    assign rsp_bufferable = rsp_q.buff;
    assign rsp_fault      = rsp_q.fault;
    assign rsp_fault_kind = rsp_q.kind;
endmodule

// File: rtl/sx_unit_chk.sv
module sx_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_resp,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_cacheable,
    input logic        rsp_bufferable,
    input logic        rsp_fault,
    input logic [1:0]  rsp_fault_kind,
    input logic [31:0] rsp_fault_addr
);
    logic [31:0] last_va;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      last_va <= '0;
        else if (req_valid && req_ready) last_va <= req_vaddr;
    end

    a_r13_ready_low_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    a_r13_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_resp) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

    a_r9_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |->
            (rsp_paddr == 32'd0 && !rsp_cacheable && !rsp_bufferable
             && rsp_fault_kind != 2'b00 && rsp_fault_addr == last_va));

    a_r9_ok_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_kind == 2'b00 && rsp_fault_addr == 32'd0));

    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[19:0] == last_va[19:0]));

    a_r10_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((req_valid && req_ready) || (mem_rd_valid && mem_rd_resp)));
endmodule

bind sx_unit sx_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_resp   (mem_rd_resp),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_cacheable (rsp_cacheable),
    .rsp_bufferable(rsp_bufferable),
    .rsp_fault     (rsp_fault),
    .rsp_fault_kind(rsp_fault_kind),
    .rsp_fault_addr(rsp_fault_addr)
);

// File: tb/sx_unit_tb.sv
`timescale 1ns/1ps
module sx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_resp = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable;
    logic        rsp_bufferable;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_kind;
    logic [31:0] rsp_fault_addr;

    always #2.5 clk = ~clk;

    sx_unit u_dut (.*);

    localparam logic [31:0] TBASE = 32'h0000_4000;
    localparam logic [31:0] GRP   = 32'hFFFF_FF93; // g0 11, g1 00, g2 01, g3 10

    logic [31:0] tbl [logic [31:0]];
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // results of the last access
    logic [31:0] r_pa, r_fa, r_faddr;
    logic        r_c, r_b, r_f;
    logic [1:0]  r_k;
    int          r_lat, r_nf;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] pa, input logic [3:0] dom,
                                       input logic [1:0] ap, input logic c, input logic b);
        return {pa, 8'h00, ap, 1'b0, dom, 1'b0, c, b, 2'b10};
    endfunction

    task automatic set_desc(input logic [11:0] tag, input logic [31:0] d);
        tbl[TBASE | ({20'd0, tag} << 2)] = d;
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue one access; mdly extra cycles of memory wait
    task automatic xlate(input logic [31:0] va, input logic wr, input int mdly);
        int  seen;
        bit  done;
        logic [31:0] hold_addr;
        seen = 0; done = 1'b0; r_nf = 0; r_lat = 0; r_faddr = '0; hold_addr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(posedge clk);
        for (int i = 0; i < 40 && !done; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            mem_rd_resp = 1'b0;
            r_lat++;
            if (rsp_valid) begin
                r_pa = rsp_paddr; r_c = rsp_cacheable; r_b = rsp_bufferable;
                r_f = rsp_fault; r_k = rsp_fault_kind; r_fa = rsp_fault_addr;
                done = 1'b1;
            end else if (mem_rd_valid) begin
                // R13: request side blocked and address steady while waiting
                chk(!req_ready, "R13", {31'd0, req_ready}, 32'd0);
                if (seen == 0) begin
                    r_nf++; r_faddr = mem_rd_addr; hold_addr = mem_rd_addr;
                end else begin
                    chk(mem_rd_addr == hold_addr, "R13", mem_rd_addr, hold_addr);
                end
                if (seen >= mdly) begin
                    mem_rd_resp = 1'b1;
                    mem_rd_data = tbl.exists(mem_rd_addr) ? tbl[mem_rd_addr] : 32'd0;
                end
                seen++;
            end
        end
        mem_rd_resp = 1'b0;
        if (!done) chk(1'b0, "R13", 32'd0, 32'd1);
    endtask

    task automatic expect_ok(input string req, input logic [31:0] pa, input logic c,
                             input logic b, input int lat);
        chk(!r_f && r_k == 2'b00, req, {30'd0, r_k}, 32'd0);
        chk(r_pa == pa, req, r_pa, pa);
        chk(r_c == c && r_b == b, req, {30'd0, r_c, r_b}, {30'd0, c, b});
        chk(r_lat == lat, req, r_lat, lat);
    endtask

    task automatic expect_fault(input string req, input logic [31:0] va, input logic [1:0] k);
        chk(r_f && r_k == k, req, {30'd0, r_k}, {30'd0, k});
        chk(r_fa == va, {req, "/R9"}, r_fa, va);
        chk(r_pa == 0 && !r_c && !r_b, "R9", r_pa, 32'd0);
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R1", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid === 1'b0 && mem_rd_valid === 1'b0, "R1",
            {30'd0, rsp_valid, mem_rd_valid}, 32'd0);
        xlate(32'h1234_5678, 1'b1, 0);
        expect_ok("R2", 32'h1234_5678, 1'b0, 1'b0, 1);
        chk(r_nf == 0, "R2", r_nf, 0);
    endtask

    task automatic t_setup;
        cfg(2'd0, 32'h0000_4ABC);
        cfg(2'd1, GRP);
        cfg(2'd3, 32'd0);
        cfg(2'd2, 32'd1);
    endtask

    task automatic t_translate;
        xlate(32'h1230_ABCD, 1'b0, 0);
        chk(r_nf == 1 && r_faddr == 32'h0000_448C, "R3", r_faddr, 32'h0000_448C);
        expect_ok("R5", 32'h4560_ABCD, 1'b1, 1'b0, 2);
        xlate(32'h0014_5678, 1'b1, 0);
        expect_ok("R5", 32'h0034_5678, 1'b0, 1'b1, 2);
    endtask

    task automatic t_hit;
        xlate(32'h1230_0004, 1'b0, 0);
        chk(r_nf == 0, "R10", r_nf, 0);
        expect_ok("R10", 32'h4560_0004, 1'b1, 1'b0, 1);
    endtask

    task automatic t_walk_wait;
        xlate(32'h0050_0010, 1'b0, 3);
        expect_ok("R13", 32'h0AB0_0010, 1'b0, 1'b0, 5);
    endtask

    task automatic t_types;
        xlate(32'h2000_0100, 1'b0, 0); expect_fault("R4", 32'h2000_0100, 2'b01);
        xlate(32'h2010_0200, 1'b0, 0); expect_fault("R4", 32'h2010_0200, 2'b01);
        xlate(32'h2020_0300, 1'b1, 0); expect_fault("R4", 32'h2020_0300, 2'b01);
    endtask

    task automatic t_domain;
        xlate(32'h3000_0040, 1'b0, 0); expect_fault("R6", 32'h3000_0040, 2'b10);
        xlate(32'h3010_0040, 1'b0, 0); expect_fault("R6", 32'h3010_0040, 2'b10);
    endtask

    task automatic t_perm;
        xlate(32'h3100_0008, 1'b0, 0); expect_fault("R8", 32'h3100_0008, 2'b11);
        xlate(32'h3110_0008, 1'b0, 0); expect_ok("R8", 32'h0110_0008, 1'b0, 1'b0, 2);
        xlate(32'h3110_000C, 1'b1, 0); expect_fault("R8", 32'h3110_000C, 2'b11);
        xlate(32'h3120_0010, 1'b1, 0); expect_ok("R8", 32'h0120_0010, 1'b0, 1'b0, 2);
        xlate(32'h3200_0014, 1'b1, 0); expect_ok("R7", 32'h0200_0014, 1'b0, 1'b0, 2);
    endtask

    task automatic t_live_groups;
        // 0x312 is cached; turn group 2 to blocked without invalidating
        cfg(2'd1, GRP & ~32'h0000_0030);
        xlate(32'h3120_0020, 1'b0, 0);
        chk(r_nf == 0 && r_lat == 1, "R10", r_nf, 0);
        expect_fault("R10", 32'h3120_0020, 2'b10);
        cfg(2'd1, GRP);
    endtask

    task automatic t_flush;
        cfg(2'd3, 32'd0);
        xlate(32'h1230_0000, 1'b0, 0);
        expect_ok("R12", 32'h4560_0000, 1'b1, 1'b0, 2);
        set_desc(12'h123, mk(12'h777, 4'd0, 2'b11, 1'b0, 1'b1));
        xlate(32'h1230_0000, 1'b0, 0);
        expect_ok("R12", 32'h4560_0000, 1'b1, 1'b0, 1);
        cfg(2'd3, 32'd0);
        xlate(32'h1230_0000, 1'b0, 0);
        chk(r_nf == 1, "R12", r_nf, 1);
        expect_ok("R12", 32'h7770_0000, 1'b0, 1'b1, 2);
    endtask

    task automatic t_rr;
        cfg(2'd3, 32'd0);
        for (int t = 0; t < 5; t++) begin
            xlate({12'h400 + 12'(t), 20'h00010}, 1'b0, 0);
            chk(r_nf == 1, "R11", r_nf, 1);
        end
        for (int t = 1; t < 5; t++) begin
            xlate({12'h400 + 12'(t), 20'h00020}, 1'b0, 0);
            chk(r_nf == 0 && r_lat == 1, "R11", r_nf, 0);
            chk(r_pa == {12'h800 + 12'(t), 20'h00020}, "R11", r_pa, {12'h800 + 12'(t), 20'h00020});
        end
        xlate(32'h4000_0030, 1'b0, 0);
        chk(r_nf == 1, "R11", r_nf, 1);
    endtask

    task automatic t_disable;
        cfg(2'd2, 32'd0);
        xlate(32'h0030_0010, 1'b0, 0);
        expect_ok("R2", 32'h0030_0010, 1'b0, 1'b0, 1);
        chk(r_nf == 0, "R2", r_nf, 0);
    endtask

    initial begin
        set_desc(12'h123, mk(12'h456, 4'd0, 2'b11, 1'b1, 1'b0));
        set_desc(12'h001, mk(12'h003, 4'd0, 2'b11, 1'b0, 1'b1));
        set_desc(12'h005, mk(12'h0AB, 4'd0, 2'b11, 1'b0, 1'b0));
        set_desc(12'h200, mk(12'h200, 4'd0, 2'b11, 1'b0, 1'b0) & ~32'h2 | 32'h1);
        set_desc(12'h201, mk(12'h201, 4'd0, 2'b11, 1'b0, 1'b0) | 32'h0004_0000);
        set_desc(12'h300, mk(12'h030, 4'd1, 2'b11, 1'b0, 1'b0));
        set_desc(12'h301, mk(12'h031, 4'd3, 2'b11, 1'b0, 1'b0));
        set_desc(12'h310, mk(12'h010, 4'd2, 2'b00, 1'b0, 1'b0));
        set_desc(12'h311, mk(12'h011, 4'd2, 2'b10, 1'b0, 1'b0));
        set_desc(12'h312, mk(12'h012, 4'd2, 2'b01, 1'b0, 1'b0));
        set_desc(12'h320, mk(12'h020, 4'd0, 2'b00, 1'b0, 1'b0));
        for (int t = 0; t < 5; t++)
            set_desc(12'h400 + 12'(t), mk(12'h800 + 12'(t), 4'd0, 2'b11, 1'b0, 1'b0));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_setup;
        t_translate;
        t_hit;
        t_walk_wait;
        t_types;
        t_domain;
        t_perm;
        t_live_groups;
        t_flush;
        t_rr;
        t_disable;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule